// File: doc/BRIEF.md
# Cascadable Bit-Slice ALU Datapath

This block is one 16-bit slice of a microprogrammed processor datapath. Every clock it takes a 10-bit microinstruction, two register addresses, a direct data word, a carry input and four shift inputs. Inside are a register file of 64 words with two read ports, a Q working register, an operand selector, an eight-function arithmetic/logic unit and a destination decoder. The decoder chooses what is stored, where it is stored, which way it is shifted and what appears on the Y output.

Several slices can sit side by side to form a wider machine. The carry, generate and propagate outputs feed the next slice or a lookahead unit. Each end of the register-file shifter and of the Q shifter has its own pin. At each end an input, an output and an output enable model one bidirectional pad, and the enable is raised only while that end is shifting out. Beyond the classic set of destinations, four extra codes can put the direct data word into the register file or Q without passing through the ALU.

The microinstruction fields are: bits 2:0 choose the operand source, bits 5:3 choose the ALU function, and bits 9:6 choose the destination.

Top module: `slice_alu`

## Requirements
- R1: While `rst_n` is low, Q is held at zero. Reset is asynchronous, so with source code 2 (R=0, S=Q), function OR (3) and destination NOP (1), Y reads 0.
- R2: The register file holds 64 words of 16 bits. It is written only at address B, on the rising clock edge. Ports A and B both read it, so a word stored with destination 8 can be read back through either address.
- R3: Operands read within a cycle show the register-file contents from before that cycle's edge. A read and a write to the same address in one cycle therefore use the old value, and the new value shows up in the next cycle.
- R4: The source codes pick the (R,S) operand pairs as follows: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0).
- R5: The function codes give F as follows: 0 R+S+cin, 1 S+~R+cin, 2 R+~S+cin, 3 R|S, 4 R&S, 5 ~R&S, 6 R^S, 7 ~(R^S).
- R6: For codes 0 to 2, the ALU works on the operands after any inversion. `cout` is the carry out of bit 15. `ovf` is the XOR of the carries into and out of bit 15. `gen` is the carry out of the sum with cin forced to 0. `prop` is 1 when every bit of the OR of the operands is 1. For codes 3 to 7, all four of these outputs are 0.
- R7: `zero` is 1 exactly when all bits of F are 0, and `sign` equals bit 15 of F.
- R8: The classic destinations behave as follows. Code 0 loads F into Q. Code 1 stores nothing. Codes 2 and 3 write F to the register file. Y shows the port A operand for code 2 and shows F for every other code.
- R9: Codes 4 and 5 write F shifted right into the register file, with bit 15 taken from `ram_hi_in`, and drive bit 0 of F on `ram_lo_out`. Codes 6 and 7 write F shifted left, with bit 0 taken from `ram_lo_in`, and drive bit 15 of F on `ram_hi_out`.
- R10: Code 4 shifts Q right, taking bit 15 from `q_hi_in`, and drives the old Q bit 0 on `q_lo_out`. Code 6 shifts Q left, taking bit 0 from `q_lo_in`, and drives the old Q bit 15 on `q_hi_out`.
- R11: The extra destinations behave as follows. Code 8 writes D to the register file. Code 9 loads D into Q. Code 10 writes F to the register file and D to Q. Code 11 writes D to the register file and F to Q. Codes 12 to 15 store nothing.
- R12: Only one end of each shifter has its enable raised at a time. An end whose enable is low drives 0 on its output.
- R13: Q keeps its value whenever the destination code is not 0, 4, 6, 9, 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of Q |
| instr | input | 10 | Microinstruction: destination[9:6], function[5:3], source[2:0] |
| addr_a | input | 6 | Read address for port A |
| addr_b | input | 6 | Read address for port B, also the write address |
| d_in | input | 16 | Direct external data |
| cin | input | 1 | Carry input |
| ram_lo_in | input | 1 | Low-end shift input for the register-file shifter |
| ram_hi_in | input | 1 | High-end shift input for the register-file shifter |
| q_lo_in | input | 1 | Low-end shift input for Q |
| q_hi_in | input | 1 | High-end shift input for Q |
| y_out | output | 16 | Y data output |
| cout | output | 1 | Carry out of the most significant bit |
| gen | output | 1 | Group carry generate |
| prop | output | 1 | Group carry propagate |
| zero | output | 1 | F is all zeros |
| sign | output | 1 | Most significant bit of F |
| ovf | output | 1 | Two's-complement overflow |
| ram_lo_out | output | 1 | Low-end shift output of the register-file shifter |
| ram_lo_oe | output | 1 | Enable for ram_lo_out |
| ram_hi_out | output | 1 | High-end shift output of the register-file shifter |
| ram_hi_oe | output | 1 | Enable for ram_hi_out |
| q_lo_out | output | 1 | Low-end shift output of Q |
| q_lo_oe | output | 1 | Enable for q_lo_out |
| q_hi_out | output | 1 | High-end shift output of Q |
| q_hi_oe | output | 1 | Enable for q_hi_out |

## Verification
The bench builds the slice with its defaults: a 16-bit word, 64 registers and the flow-through read stage (READ_REG=0). With these values every register address can be reached, and an edge at bit 15 gives a real overflow boundary. A reference model kept in the bench predicts every output in every cycle. The directed tasks step through each source, function and destination code, load all 64 words, and run a read and write of the same address in back-to-back cycles. A long pseudo-random run then mixes all the fields. The registered-read variant is not exercised by this bench.

// File: rtl/slice_pkg.sv
package slice_pkg;

   localparam int INSTR_W = 10;

   typedef enum logic [2:0] {
      SRC_AQ, SRC_AB, SRC_ZQ, SRC_ZB, SRC_ZA, SRC_DA, SRC_DQ, SRC_DZ
   } src_e;

   typedef enum logic [2:0] {
      FN_ADD, FN_SUBR, FN_SUBS, FN_OR, FN_AND, FN_NOTRS, FN_XOR, FN_XNOR
   } fn_e;

   typedef enum logic [3:0] {
      DST_QREG, DST_NOP, DST_RAMA, DST_RAMF,
      DST_RAMQD, DST_RAMD, DST_RAMQU, DST_RAMU,
      DST_LDR, DST_LDQ, DST_FR_DQ, DST_DR_FQ,
      DST_R12, DST_R13, DST_R14, DST_R15
   } dst_e;

   typedef enum logic [1:0] { WSEL_F, WSEL_DN, WSEL_UP, WSEL_D } wsel_e;

   typedef struct packed {
      logic  ram_we;
      wsel_e ram_sel;
      logic  q_we;
      wsel_e q_sel;
      logic  y_from_a;
   } dst_ctl_t;

   function automatic dst_ctl_t decode_dst(input logic [3:0] code);
      dst_ctl_t c;
      c = '{ram_we: 1'b0, ram_sel: WSEL_F, q_we: 1'b0, q_sel: WSEL_F, y_from_a: 1'b0};
      case (dst_e'(code))
         DST_QREG:  begin c.q_we = 1'b1; end
         DST_RAMA:  begin c.ram_we = 1'b1; c.y_from_a = 1'b1; end
         DST_RAMF:  begin c.ram_we = 1'b1; end
         DST_RAMQD: begin c.ram_we = 1'b1; c.ram_sel = WSEL_DN;
                          c.q_we = 1'b1; c.q_sel = WSEL_DN; end
         DST_RAMD:  begin c.ram_we = 1'b1; c.ram_sel = WSEL_DN; end
         DST_RAMQU: begin c.ram_we = 1'b1; c.ram_sel = WSEL_UP;
                          c.q_we = 1'b1; c.q_sel = WSEL_UP; end
         DST_RAMU:  begin c.ram_we = 1'b1; c.ram_sel = WSEL_UP; end
         DST_LDR:   begin c.ram_we = 1'b1; c.ram_sel = WSEL_D; end
         DST_LDQ:   begin c.q_we = 1'b1; c.q_sel = WSEL_D; end
         DST_FR_DQ: begin c.ram_we = 1'b1; c.q_we = 1'b1; c.q_sel = WSEL_D; end
         DST_DR_FQ: begin c.ram_we = 1'b1; c.ram_sel = WSEL_D; c.q_we = 1'b1; end
         default:   begin end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/slice_regfile.sv
module slice_regfile #(
   parameter int W        = 16,
   parameter int DEPTH    = 64,
   parameter int AW       = 6,
   parameter bit READ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   input  logic [W-1:0]  wd,
   output logic [W-1:0]  rd_a,
   output logic [W-1:0]  rd_b
);

   logic [W-1:0] mem [DEPTH];

   // write port shares the B address
   always_ff @(posedge clk) begin
      if (we) mem[ra_b] <= wd;
   end

   generate
      if (READ_REG) begin : g_reg_read
         // operands captured at the edge, used one cycle later
         always_ff @(posedge clk) begin
            rd_a <= mem[ra_a];
            rd_b <= mem[ra_b];
         end
      end else begin : g_flow_read
         // holds pre-edge contents for the whole cycle; write lands after
         assign rd_a = mem[ra_a];
         assign rd_b = mem[ra_b];
      end
   endgenerate

endmodule

// File: rtl/slice_opsel.sv
module slice_opsel
   import slice_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [2:0]   src,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] q,
   input  logic [W-1:0] d,
   output logic [W-1:0] r,
   output logic [W-1:0] s
);

   always_comb begin
      r = '0;
      s = '0;
      case (src_e'(src))
         SRC_AQ: begin r = a;  s = q;  end
         SRC_AB: begin r = a;  s = b;  end
         SRC_ZQ: begin r = '0; s = q;  end
         SRC_ZB: begin r = '0; s = b;  end
         SRC_ZA: begin r = '0; s = a;  end
         SRC_DA: begin r = d;  s = a;  end
         SRC_DQ: begin r = d;  s = q;  end
         SRC_DZ: begin r = d;  s = '0; end
         default: begin end
      endcase
   end

endmodule

// File: rtl/slice_alu_core.sv
module slice_alu_core
   import slice_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [2:0]   fn,
   input  logic [W-1:0] r,
   input  logic [W-1:0] s,
   input  logic         cin,
   output logic [W-1:0] f,
   output logic         cout,
   output logic         gen,
   output logic         prop,
   output logic         ovf,
   output logic         zero,
   output logic         sign
);

   logic [W-1:0] ro, so;
   logic [W-1:0] lo_sum;
   logic [1:0]   hi_sum;
   logic [W-1:0] arith_f;
   logic         is_arith;

   always_comb begin
      ro = r;
      so = s;
      if (fn_e'(fn) == FN_SUBR) ro = ~r;
      if (fn_e'(fn) == FN_SUBS) so = ~s;
   end

   // low bits and MSB added apart so the carry into the MSB is visible
   assign lo_sum  = {1'b0, ro[W-2:0]} + {1'b0, so[W-2:0]} + {{(W-1){1'b0}}, cin};
   assign hi_sum  = {1'b0, ro[W-1]} + {1'b0, so[W-1]} + {1'b0, lo_sum[W-1]};
   assign arith_f = {hi_sum[0], lo_sum[W-2:0]};
   assign is_arith = (fn_e'(fn) == FN_ADD) || (fn_e'(fn) == FN_SUBR) || (fn_e'(fn) == FN_SUBS);

   always_comb begin
      case (fn_e'(fn))
         FN_OR:    f = r | s;
         FN_AND:   f = r & s;
         FN_NOTRS: f = ~r & s;
         FN_XOR:   f = r ^ s;
         FN_XNOR:  f = ~(r ^ s);
         default:  f = arith_f;
      endcase
   end

   assign cout = is_arith & hi_sum[1];
   assign ovf  = is_arith & (hi_sum[1] ^ lo_sum[W-1]);
   assign gen  = is_arith & (({1'b0, ro} + {1'b0, so}) > {1'b0, {W{1'b1}}});
   assign prop = is_arith & (&(ro | so));
   assign zero = (f == '0);
   assign sign = f[W-1];

endmodule

// File: rtl/slice_dest.sv
module slice_dest
   import slice_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [3:0]   code,
   input  logic [W-1:0] f,
   input  logic [W-1:0] q,
   input  logic [W-1:0] a_op,
   input  logic [W-1:0] d,
   input  logic         ram_lo_in,
   input  logic         ram_hi_in,
   input  logic         q_lo_in,
   input  logic         q_hi_in,
   output logic         ram_we,
   output logic [W-1:0] ram_wd,
   output logic         q_we,
   output logic [W-1:0] q_nxt,
   output logic [W-1:0] y,
   output logic         ram_lo_out,
   output logic         ram_lo_oe,
   output logic         ram_hi_out,
   output logic         ram_hi_oe,
   output logic         q_lo_out,
   output logic         q_lo_oe,
   output logic         q_hi_out,
   output logic         q_hi_oe
);

   dst_ctl_t ctl;
   assign ctl = decode_dst(code);

   always_comb begin
      case (ctl.ram_sel)
         WSEL_DN: ram_wd = {ram_hi_in, f[W-1:1]};
         WSEL_UP: ram_wd = {f[W-2:0], ram_lo_in};
         WSEL_D:  ram_wd = d;
         default: ram_wd = f;
      endcase
      case (ctl.q_sel)
         WSEL_DN: q_nxt = {q_hi_in, q[W-1:1]};
         WSEL_UP: q_nxt = {q[W-2:0], q_lo_in};
         WSEL_D:  q_nxt = d;
         default: q_nxt = f;
      endcase
   end

   assign ram_we = ctl.ram_we;
   assign q_we   = ctl.q_we;
   assign y      = ctl.y_from_a ? a_op : f;

   // pad enables: an end drives only while its shifter pushes out there
   assign ram_lo_oe  = ctl.ram_we && (ctl.ram_sel == WSEL_DN);
   assign ram_hi_oe  = ctl.ram_we && (ctl.ram_sel == WSEL_UP);
   assign q_lo_oe    = ctl.q_we && (ctl.q_sel == WSEL_DN);
   assign q_hi_oe    = ctl.q_we && (ctl.q_sel == WSEL_UP);
   assign ram_lo_out = ram_lo_oe & f[0];
   assign ram_hi_out = ram_hi_oe & f[W-1];
   assign q_lo_out   = q_lo_oe & q[0];
   assign q_hi_out   = q_hi_oe & q[W-1];

endmodule

// File: rtl/slice_alu.sv
module slice_alu
   import slice_pkg::*;
#(
   parameter int W        = 16,
   parameter int DEPTH    = 64,
   parameter bit READ_REG = 1'b0,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic [AW-1:0]      addr_a,
   input  logic [AW-1:0]      addr_b,
   input  logic [W-1:0]       d_in,
   input  logic               cin,
   input  logic               ram_lo_in,
   input  logic               ram_hi_in,
   input  logic               q_lo_in,
   input  logic               q_hi_in,
   output logic [W-1:0]       y_out,
   output logic               cout,
   output logic               gen,
   output logic               prop,
   output logic               zero,
   output logic               sign,
   output logic               ovf,
   output logic               ram_lo_out,
   output logic               ram_lo_oe,
   output logic               ram_hi_out,
   output logic               ram_hi_oe,
   output logic               q_lo_out,
   output logic               q_lo_oe,
   output logic               q_hi_out,
   output logic               q_hi_oe
);

   generate
      if (W < 4) begin : g_bad_width
         $error("slice_alu: W must be at least 4");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("slice_alu: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [2:0]   f_src, f_fn;
   logic [3:0]   f_dst;
   logic [W-1:0] a_op, b_op, r_op, s_op, f_val;
   logic [W-1:0] q_reg, q_nxt, ram_wd;
   logic         ram_we, q_we;

   assign f_src = instr[2:0];
   assign f_fn  = instr[5:3];
   assign f_dst = instr[9:6];

   slice_regfile #(.W(W), .DEPTH(DEPTH), .AW(AW), .READ_REG(READ_REG)) u_rf (
      .clk  (clk),
      .we   (ram_we),
      .ra_a (addr_a),
      .ra_b (addr_b),
      .wd   (ram_wd),
      .rd_a (a_op),
      .rd_b (b_op)
   );

   slice_opsel #(.W(W)) u_sel (
      .src (f_src),
      .a   (a_op),
      .b   (b_op),
      .q   (q_reg),
      .d   (d_in),
      .r   (r_op),
      .s   (s_op)
   );

   slice_alu_core #(.W(W)) u_core (
      .fn   (f_fn),
      .r    (r_op),
      .s    (s_op),
      .cin  (cin),
      .f    (f_val),
      .cout (cout),
      .gen  (gen),
      .prop (prop),
      .ovf  (ovf),
      .zero (zero),
      .sign (sign)
   );

   slice_dest #(.W(W)) u_dst (
      .code       (f_dst),
      .f          (f_val),
      .q          (q_reg),
      .a_op       (a_op),
      .d          (d_in),
      .ram_lo_in  (ram_lo_in),
      .ram_hi_in  (ram_hi_in),
      .q_lo_in    (q_lo_in),
      .q_hi_in    (q_hi_in),
      .ram_we     (ram_we),
      .ram_wd     (ram_wd),
      .q_we       (q_we),
      .q_nxt      (q_nxt),
      .y          (y_out),
      .ram_lo_out (ram_lo_out),
      .ram_lo_oe  (ram_lo_oe),
      .ram_hi_out (ram_hi_out),
      .ram_hi_oe  (ram_hi_oe),
      .q_lo_out   (q_lo_out),
      .q_lo_oe    (q_lo_oe),
      .q_hi_out   (q_hi_out),
      .q_hi_oe    (q_hi_oe)
   );

   // Q working register (R1 reset, R13 hold)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_reg <= '0;
      else if (q_we) q_reg <= q_nxt;
   end

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   fn,
   input logic [3:0]   dst,
   input logic [W-1:0] d_in,
   input logic [W-1:0] q_reg,
   input logic         q_we,
   input logic [W-1:0] y_out,
   input logic         cout,
   input logic         gen,
   input logic         prop,
   input logic         ovf,
   input logic         zero,
   input logic         ram_lo_oe,
   input logic         ram_lo_out,
   input logic         ram_hi_oe,
   input logic         ram_hi_out,
   input logic         q_lo_oe,
   input logic         q_lo_out,
   input logic         q_hi_oe,
   input logic         q_hi_out
);

   a_r13_q_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !q_we |=> q_reg == $past(q_reg));

   a_r11_direct_q: assert property (@(posedge clk) disable iff (!rst_n)
      (dst == 4'd9) |=> q_reg == $past(d_in));

   a_r6_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (fn >= 3'd3) |-> (!cout && !ovf && !gen && !prop));

   a_r7_zero_y: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && dst != 4'd2) |-> y_out == '0);

   a_r9_up_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (dst == 4'd7) |-> (ram_hi_oe && ram_hi_out == y_out[W-1]));

   a_r12_ends_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_lo_oe && ram_hi_oe) && !(q_lo_oe && q_hi_oe));

   a_r12_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_lo_oe |-> !ram_lo_out) and (!ram_hi_oe |-> !ram_hi_out) and
      (!q_lo_oe |-> !q_lo_out) and (!q_hi_oe |-> !q_hi_out));

endmodule

bind slice_alu slice_alu_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fn         (instr[5:3]),
   .dst        (instr[9:6]),
   .d_in       (d_in),
   .q_reg      (q_reg),
   .q_we       (q_we),
   .y_out      (y_out),
   .cout       (cout),
   .gen        (gen),
   .prop       (prop),
   .ovf        (ovf),
   .zero       (zero),
   .ram_lo_oe  (ram_lo_oe),
   .ram_lo_out (ram_lo_out),
   .ram_hi_oe  (ram_hi_oe),
   .ram_hi_out (ram_hi_out),
   .q_lo_oe    (q_lo_oe),
   .q_lo_out   (q_lo_out),
   .q_hi_oe    (q_hi_oe),
   .q_hi_out   (q_hi_out)
);

// File: tb/slice_alu_test.sv
module slice_alu_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  instr = '0;
   logic [5:0]  addr_a = '0, addr_b = '0;
   logic [15:0] d_in = '0;
   logic        cin = 1'b0;
   logic        ram_lo_in = 1'b0, ram_hi_in = 1'b0, q_lo_in = 1'b0, q_hi_in = 1'b0;
   logic [15:0] y_out;
   logic        cout, gen, prop, zero, sign, ovf;
   logic        ram_lo_out, ram_lo_oe, ram_hi_out, ram_hi_oe;
   logic        q_lo_out, q_lo_oe, q_hi_out, q_hi_oe;

   int checks = 0;
   int fails  = 0;

   logic [15:0] m_ram [64];
   logic [15:0] m_q = '0;
   logic [31:0] lfsr = 32'h1D2C_3B4A;

   always #10 clk = ~clk;

   slice_alu uut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .addr_a(addr_a), .addr_b(addr_b),
      .d_in(d_in), .cin(cin), .ram_lo_in(ram_lo_in), .ram_hi_in(ram_hi_in),
      .q_lo_in(q_lo_in), .q_hi_in(q_hi_in), .y_out(y_out), .cout(cout),
      .gen(gen), .prop(prop), .zero(zero), .sign(sign), .ovf(ovf),
      .ram_lo_out(ram_lo_out), .ram_lo_oe(ram_lo_oe),
      .ram_hi_out(ram_hi_out), .ram_hi_oe(ram_hi_oe),
      .q_lo_out(q_lo_out), .q_lo_oe(q_lo_oe),
      .q_hi_out(q_hi_out), .q_hi_oe(q_hi_oe)
   );

   // One cycle: drive at falling edge, compare mid-low-phase, advance model.
   task automatic step(input logic [9:0] i, input logic [5:0] a, input logic [5:0] b,
                       input logic [15:0] d, input logic c, input logic [3:0] pins,
                       input string tag);
      logic [15:0] av, bv, r, s, ro, so, f, y, rwd, qn;
      logic [16:0] full, lo, g17;
      logic co, g, p, v, z, sg, rl_oe, rh_oe, ql_oe, qh_oe, rwe, qwe;
      logic [29:0] exp_v, act_v;
      logic [2:0] src, fn;
      logic [3:0] dc;
      @(negedge clk);
      instr = i; addr_a = a; addr_b = b; d_in = d; cin = c;
      {ram_lo_in, ram_hi_in, q_lo_in, q_hi_in} = pins;
      #5;
      src = i[2:0]; fn = i[5:3]; dc = i[9:6];
      av = m_ram[a]; bv = m_ram[b];
      case (src)
         3'd0: begin r = av; s = m_q; end
         3'd1: begin r = av; s = bv; end
         3'd2: begin r = '0; s = m_q; end
         3'd3: begin r = '0; s = bv; end
         3'd4: begin r = '0; s = av; end
         3'd5: begin r = d;  s = av; end
         3'd6: begin r = d;  s = m_q; end
         default: begin r = d; s = '0; end
      endcase
      ro = (fn == 3'd1) ? ~r : r;
      so = (fn == 3'd2) ? ~s : s;
      full = {1'b0, ro} + {1'b0, so} + {16'd0, c};
      lo   = {2'b0, ro[14:0]} + {2'b0, so[14:0]} + {16'd0, c};
      g17  = {1'b0, ro} + {1'b0, so};
      co = 0; g = 0; p = 0; v = 0;
      case (fn)
         3'd3: f = r | s;
         3'd4: f = r & s;
         3'd5: f = ~r & s;
         3'd6: f = r ^ s;
         3'd7: f = ~(r ^ s);
         default: begin
            f = full[15:0]; co = full[16]; v = full[16] ^ lo[15];
            g = g17[16]; p = &(ro | so);
         end
      endcase
      z = (f == 16'd0); sg = f[15];
      y = (dc == 4'd2) ? av : f;
      rl_oe = (dc == 4'd4) || (dc == 4'd5);
      rh_oe = (dc == 4'd6) || (dc == 4'd7);
      ql_oe = (dc == 4'd4);
      qh_oe = (dc == 4'd6);
      rwe = (dc >= 4'd2 && dc <= 4'd8) || dc == 4'd10 || dc == 4'd11;
      qwe = dc == 4'd0 || dc == 4'd4 || dc == 4'd6 || dc == 4'd9 || dc == 4'd10 || dc == 4'd11;
      if (rl_oe)                     rwd = {pins[2], f[15:1]};
      else if (rh_oe)                rwd = {f[14:0], pins[3]};
      else if (dc == 4'd8 || dc == 4'd11) rwd = d;
      else                           rwd = f;
      if (dc == 4'd4)                qn = {pins[0], m_q[15:1]};
      else if (dc == 4'd6)           qn = {m_q[14:0], pins[1]};
      else if (dc == 4'd9 || dc == 4'd10) qn = d;
      else                           qn = f;
      exp_v = {y, co, g, p, z, sg, v,
               rl_oe & f[0], rl_oe, rh_oe & f[15], rh_oe,
               ql_oe & m_q[0], ql_oe, qh_oe & m_q[15], qh_oe};
      act_v = {y_out, cout, gen, prop, zero, sign, ovf,
               ram_lo_out, ram_lo_oe, ram_hi_out, ram_hi_oe,
               q_lo_out, q_lo_oe, q_hi_out, q_hi_oe};
      checks++;
      if (act_v !== exp_v) begin
         fails++;
         $display("FAIL %s instr=%h a=%0d b=%0d actual=%h expected=%h",
                  tag, i, a, b, act_v, exp_v);
      end
      if (rwe) m_ram[b] = rwd;
      if (qwe && rst_n) m_q = qn;
   endtask

   function automatic logic [9:0] mk(input int dc, input int fn, input int src);
      return {dc[3:0], fn[2:0], src[2:0]};
   endfunction

   function automatic string dst_tag(input int dc);
      if (dc >= 8)                 return "R11";
      if (dc == 4 || dc == 6)      return "R10";
      if (dc == 5 || dc == 7)      return "R9";
      return "R8";
   endfunction

   task automatic t_reset;
      // R1: Q zero while reset held, visible via (0,Q) OR, NOP
      step(mk(1, 3, 2), 6'd0, 6'd0, 16'hFFFF, 1'b0, 4'h0, "R1");
      @(negedge clk); rst_n = 1'b1;
      step(mk(1, 3, 2), 6'd0, 6'd0, 16'h1234, 1'b0, 4'h0, "R1");
   endtask

   task automatic t_fill;
      // R2: direct-load every word at B, then read back through A and B
      for (int k = 0; k < 64; k++)
         step(mk(8, 3, 7), 6'(k), 6'(k), 16'(k * 16'h0403) ^ 16'hA5C3, 1'b0, 4'h0, "R2");
      for (int k = 0; k < 64; k++) begin
         step(mk(1, 0, 4), 6'(k), 6'(63 - k), 16'h0, 1'b0, 4'h0, "R2");
         step(mk(1, 0, 3), 6'(63 - k), 6'(k), 16'h0, 1'b0, 4'h0, "R2");
      end
   endtask

   task automatic t_same_addr;
      // R3: increment reg 10 in place twice; each cycle sees the old value
      step(mk(3, 0, 4), 6'd10, 6'd10, 16'h0, 1'b1, 4'h0, "R3");
      step(mk(3, 0, 4), 6'd10, 6'd10, 16'h0, 1'b1, 4'h0, "R3");
      step(mk(1, 0, 4), 6'd10, 6'd10, 16'h0, 1'b0, 4'h0, "R3");
   endtask

   task automatic t_sources;
      step(mk(0, 3, 7), 6'd0, 6'd0, 16'h5A0F, 1'b0, 4'h0, "R4"); // Q known
      for (int sc = 0; sc < 8; sc++)
         step(mk(1, 0, sc), 6'd3, 6'd17, 16'h0F31, 1'b0, 4'h0, "R4");
   endtask

   task automatic t_functions;
      for (int fc = 0; fc < 8; fc++) begin
         step(mk(1, fc, 5), 6'd7, 6'd0, 16'hC3A5, 1'b0, 4'h0, "R5");
         step(mk(1, fc, 5), 6'd7, 6'd0, 16'h0001, 1'b1, 4'h0, "R5");
      end
   endtask

   task automatic t_arith_edges;
      // R6: signed overflow, unsigned carry, propagate-only, subtract to zero
      step(mk(8, 3, 7), 6'd0, 6'd1, 16'h0001, 1'b0, 4'h0, "R6");
      step(mk(1, 0, 5), 6'd1, 6'd0, 16'h7FFF, 1'b0, 4'h0, "R6");
      step(mk(1, 0, 5), 6'd1, 6'd0, 16'hFFFF, 1'b0, 4'h0, "R6");
      step(mk(1, 0, 5), 6'd1, 6'd0, 16'hFFFE, 1'b1, 4'h0, "R6");
      step(mk(1, 1, 5), 6'd1, 6'd0, 16'h0001, 1'b1, 4'h0, "R6");
      step(mk(1, 2, 5), 6'd1, 6'd0, 16'h8000, 1'b1, 4'h0, "R6");
      // R7: zero and sign
      step(mk(1, 3, 7), 6'd0, 6'd0, 16'h0000, 1'b0, 4'h0, "R7");
      step(mk(1, 3, 7), 6'd0, 6'd0, 16'h8000, 1'b0, 4'h0, "R7");
   endtask

   task automatic t_destinations;
      for (int dc = 0; dc < 16; dc++) begin
         for (int pv = 0; pv < 2; pv++) begin
            step(mk(0, 3, 7), 6'd0, 6'd0, 16'h8001 ^ 16'(dc * 16'h0110), 1'b0, 4'h0, "R13");
            step(mk(dc, 0, 5), 6'd20, 6'(30 + dc),
                 16'h4C3B, 1'b0, pv ? 4'hF : 4'h0, dst_tag(dc));
            step(mk(1, 0, 3), 6'd0, 6'(30 + dc), 16'h0, 1'b0, 4'h0, "R2");
            step(mk(1, 3, 2), 6'd0, 6'd0, 16'h0, 1'b0, 4'h0, "R13");
         end
      end
   endtask

   task automatic t_random;
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] x;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         x = lfsr * 32'h9E37_79B9;
         step(x[9:0], x[15:10], x[21:16], x[31:16] ^ x[15:0], x[22], x[26:23], "R12");
      end
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #3;
      t_reset();
      t_fill();
      t_same_addr();
      t_sources();
      t_functions();
      t_arith_edges();
      t_destinations();
      t_random();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule